// File: doc/BRIEF.md
# Strap-ID Register Decoder

This block sits on the device side of a shared firmware bus that carries several devices. Each bus cycle arrives already parsed into an ID field, an address, and a read/write flag. The block compares the ID with the value on its strap pins. A cycle meant for another device is dropped, and the block reports standby. A cycle that carries this device's ID wakes the block. The block then decodes a small register window. One location in the window passes five general-purpose input pins straight through. Every other location in the window reads as zero.

The window moves with the strap value. The first device on the bus is strapped as ID 0, and its window starts at FFBC0000h. Each higher ID moves the window down by a fixed stride. While the device is busy with an internal program or erase, every register access is dropped. A dropped read gives the bus master no response strobe.

Top module: `strap_reg_decoder`

## Requirements
- R1: While reset is high, and in the cycle after reset, `standby` is 1, `rsp_valid` and `wr_ack` are 0, and `rsp_data` is 00h.
- R2: A cycle whose `cyc_id` differs from `strap_id` gives no `rsp_valid` and no `wr_ack`. `standby` is 1 in the cycle after it.
- R3: A cycle whose `cyc_id` equals `strap_id` drives `standby` to 0 in the cycle after it, whether or not the cycle is served.
- R4: The window base is FFBC0000h minus `strap_id` times 400000h. A matched, idle read at base+0100h returns `rsp_valid`=1 one cycle later. `rsp_data` bits 4:0 carry `gpi_pins` as sampled in the cycle-start clock, and bits 7:5 read 0.
- R5: A matched, idle read at any other offset from 0000h to FFFFh in the window returns `rsp_valid`=1 with `rsp_data`=00h.
- R6: A matched cycle whose address lies outside the 64 KiB window gives no `rsp_valid` and no `wr_ack`.
- R7: A matched cycle that starts while `wr_busy` is 1 gives no `rsp_valid` and no `wr_ack`, for a read or a write.
- R8: A matched, idle write inside the window pulses `wr_ack` for one cycle and changes nothing. Later reads still return the live pins at the input location and 00h at other locations.
- R9: `rsp_valid` and `wr_ack` are never both 1. Each strobe lasts one cycle for each cycle start.
- R10: With `cyc_valid` low, neither strobe fires and `standby` keeps its value.
- R11: When `rsp_valid` is 0, `rsp_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | One-cycle pulse marking a parsed bus cycle |
| cyc_id | input | 4 | Device ID field of the cycle |
| cyc_addr | input | 32 | Byte address of the cycle |
| cyc_we | input | 1 | 1 for write, 0 for read |
| strap_id | input | 4 | Strapped device ID, held static |
| gpi_pins | input | 5 | General-purpose input pins |
| wr_busy | input | 1 | Internal program/erase in progress |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | 8 | Read data |
| wr_ack | output | 1 | Write accepted strobe |
| standby | output | 1 | 1 after a cycle for another device, or after reset |

## Verification
The bench keeps the default parameters: a 32-bit address, a 4-bit ID, 8-bit data, five input pins, and a window stride of 400000h. It changes the strap input across 0, 3 and 15. Strap 15 places the window lowest, at FBFC0000h, so both the base arithmetic and the per-ID offset are exercised at their extreme. At each strap value the bench tries the window's first and last bytes and the addresses just outside each end. It also tries foreign IDs, a busy device, and reads while the pins change from one cycle to the next.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int unsigned SRD_ADDR_W = 32;
  localparam int unsigned SRD_ID_W   = 4;
  localparam int unsigned SRD_DATA_W = 8;
  localparam int unsigned SRD_GPI_W  = 5;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } srd_acc_e;
endpackage

// File: rtl/srd_id_cmp.sv
module srd_id_cmp #(
  parameter int unsigned ID_W = 4
) (
  input  logic [ID_W-1:0] cyc_id,
  input  logic [ID_W-1:0] strap_id,
  output logic            hit
);
  always_comb hit = (cyc_id == strap_id);
endmodule

// File: rtl/srd_window.sv
module srd_window #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFBC_0000,
  parameter logic [ADDR_W-1:0] ID_STRIDE = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] GPI_OFS   = 32'h0000_0100
) (
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [ID_W-1:0]   strap_id,
  output logic              in_win,
  output logic              is_gpi
);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(1) << WIN_BITS;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    base   = BOOT_BASE - (ADDR_W'(strap_id) * ID_STRIDE);
    offset = cyc_addr - base;
    in_win = (offset < WIN_SIZE);
    is_gpi = in_win && (offset == GPI_OFS);
  end
endmodule

// File: rtl/srd_resp.sv
module srd_resp
  import srd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GPI_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic              id_hit,
  input  srd_acc_e          acc,
  input  logic              is_gpi,
  input  logic [GPI_W-1:0]  gpi_pins,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wr_ack,
  output logic              standby
);
  logic [DATA_W-1:0] gpi_word;

  generate
    if (DATA_W > GPI_W) begin : g_pad
      always_comb gpi_word = {{(DATA_W-GPI_W){1'b0}}, gpi_pins};
    end else begin : g_nopad
      always_comb gpi_word = gpi_pins[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      wr_ack    <= 1'b0;
      standby   <= 1'b1;
    end else begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      wr_ack    <= 1'b0;
      if (cyc_valid) begin
        standby <= ~id_hit;
        case (acc)
          ACC_READ: begin
            rsp_valid <= 1'b1;
            rsp_data  <= is_gpi ? gpi_word : '0;
          end
          ACC_WRITE: wr_ack <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/strap_reg_decoder.sv
module strap_reg_decoder
  import srd_pkg::*;
#(
  parameter int unsigned ADDR_W   = SRD_ADDR_W,
  parameter int unsigned ID_W     = SRD_ID_W,
  parameter int unsigned DATA_W   = SRD_DATA_W,
  parameter int unsigned GPI_W    = SRD_GPI_W,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFBC_0000,
  parameter logic [ADDR_W-1:0] ID_STRIDE = 32'h0040_0000,
  parameter logic [ADDR_W-1:0] GPI_OFS   = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic [ID_W-1:0]   cyc_id,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_we,
  input  logic [ID_W-1:0]   strap_id,
  input  logic [GPI_W-1:0]  gpi_pins,
  input  logic              wr_busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wr_ack,
  output logic              standby
);
  logic     id_hit;
  logic     in_win;
  logic     is_gpi;
  srd_acc_e acc;

  srd_id_cmp #(.ID_W(ID_W)) u_id (
    .cyc_id   (cyc_id),
    .strap_id (strap_id),
    .hit      (id_hit)
  );

  srd_window #(
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W),
    .WIN_BITS  (WIN_BITS),
    .BOOT_BASE (BOOT_BASE),
    .ID_STRIDE (ID_STRIDE),
    .GPI_OFS   (GPI_OFS)
  ) u_win (
    .cyc_addr (cyc_addr),
    .strap_id (strap_id),
    .in_win   (in_win),
    .is_gpi   (is_gpi)
  );

  always_comb begin
    if (!id_hit || wr_busy || !in_win) acc = ACC_NONE;
    else if (cyc_we)                   acc = ACC_WRITE;
    else                               acc = ACC_READ;
  end

  srd_resp #(.DATA_W(DATA_W), .GPI_W(GPI_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .cyc_valid (cyc_valid),
    .id_hit    (id_hit),
    .acc       (acc),
    .is_gpi    (is_gpi),
    .gpi_pins  (gpi_pins),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .wr_ack    (wr_ack),
    .standby   (standby)
  );
endmodule

// File: rtl/srd_chk.sv
module srd_chk #(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GPI_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_valid,
  input logic [ID_W-1:0]   cyc_id,
  input logic [ID_W-1:0]   strap_id,
  input logic              wr_busy,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              wr_ack,
  input logic              standby
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (standby && !rsp_valid && !wr_ack && rsp_data == '0)); // R1
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst) (cyc_valid && cyc_id != strap_id) |=> (standby && !rsp_valid && !wr_ack)); // R2
  AST_OWN_WAKE: assert property (@(posedge clk) disable iff (rst) (cyc_valid && cyc_id == strap_id) |=> !standby); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> (rsp_data[DATA_W-1:GPI_W] == '0)); // R4
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst) (cyc_valid && wr_busy) |=> (!rsp_valid && !wr_ack)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(rsp_valid && wr_ack)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !cyc_valid |=> (!rsp_valid && !wr_ack && $stable(standby))); // R10
  AST_DATA_BLANK: assert property (@(posedge clk) disable iff (rst) !rsp_valid |-> (rsp_data == '0)); // R11
endmodule

bind strap_reg_decoder srd_chk #(.ID_W(ID_W), .DATA_W(DATA_W), .GPI_W(GPI_W)) u_srd_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_valid (cyc_valid),
  .cyc_id    (cyc_id),
  .strap_id  (strap_id),
  .wr_busy   (wr_busy),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .wr_ack    (wr_ack),
  .standby   (standby)
);

// File: tb/tb_strap_reg_decoder.sv
module tb_strap_reg_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_valid = 1'b0;
  logic [3:0]  cyc_id = '0;
  logic [31:0] cyc_addr = '0;
  logic        cyc_we = 1'b0;
  logic [3:0]  strap_id = '0;
  logic [4:0]  gpi_pins = '0;
  logic        wr_busy = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        wr_ack;
  logic        standby;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit started = 1'b0;
  bit done    = 1'b0;

  bit         e_rv, e_wa, e_sb;
  logic [7:0] e_d;
  string      e_req;

  always #5 clk = ~clk;

  strap_reg_decoder dut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_id(cyc_id),
    .cyc_addr(cyc_addr), .cyc_we(cyc_we), .strap_id(strap_id),
    .gpi_pins(gpi_pins), .wr_busy(wr_busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .wr_ack(wr_ack), .standby(standby)
  );

  // Behavioural reference model, evaluated on every rising edge
  always @(posedge clk) begin
    longint base, ofs;
    started <= 1'b1;
    e_rv = 0; e_wa = 0; e_d = 8'h00;
    if (rst) begin
      e_sb = 1; e_req = "R1";
    end else if (!cyc_valid) begin
      e_req = "R10";
    end else if (cyc_id != strap_id) begin
      e_sb = 1; e_req = "R2";
    end else begin
      e_sb = 0;
      base = 64'hFFBC_0000 - longint'(strap_id) * 64'h40_0000;
      ofs  = longint'(cyc_addr) - base;
      if (wr_busy) e_req = "R3 R7";
      else if (ofs < 0 || ofs > 65535) e_req = "R3 R6";
      else if (cyc_we) begin
        e_wa = 1; e_req = "R8";
      end else begin
        e_rv = 1;
        if (ofs == 256) begin
          e_d = {3'b000, gpi_pins}; e_req = "R4";
        end else e_req = "R5";
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_tests++;
      if (rsp_valid !== e_rv || wr_ack !== e_wa || standby !== e_sb || rsp_data !== e_d) begin
        n_fail++;
        $display("FAIL %s: rv/wa/sb/d actual %b/%b/%b/%h expected %b/%b/%b/%h",
                 e_req, rsp_valid, wr_ack, standby, rsp_data, e_rv, e_wa, e_sb, e_d);
      end
      n_tests++;
      if (rsp_valid === 1'b1 && wr_ack === 1'b1) begin
        n_fail++;
        $display("FAIL R9: both strobes actual 1/1 expected not both");
      end
      n_tests++;
      if (rsp_valid !== 1'b1 && rsp_data !== 8'h00) begin
        n_fail++;
        $display("FAIL R11: idle data actual %h expected 00", rsp_data);
      end
    end
  end

  task automatic cyc(input logic [3:0] id, input logic [31:0] a,
                     input logic we, input logic busy);
    cyc_valid = 1'b1; cyc_id = id; cyc_addr = a; cyc_we = we; wr_busy = busy;
    @(negedge clk);
    cyc_valid = 1'b0; wr_busy = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strap_phase(input logic [3:0] s);
    logic [31:0] b;
    b = 32'hFFBC_0000 - {28'd0, s} * 32'h40_0000;
    strap_id = s;
    idle(2);
    cyc(s, b + 32'h100, 1'b0, 1'b0);          // R4 input register
    cyc(s, b, 1'b0, 1'b0);                    // R5 first byte
    cyc(s, b + 32'hFFFF, 1'b0, 1'b0);         // R5 last byte
    cyc(s, b + 32'h1_0000, 1'b0, 1'b0);       // R6 just above
    cyc(s, b - 32'h1, 1'b0, 1'b0);            // R6 just below
    cyc(s, b + 32'h100, 1'b1, 1'b0);          // R8 write
    cyc(s, b + 32'h100, 1'b0, 1'b0);          // R8 readback
    cyc(s, b + 32'h40, 1'b1, 1'b0);           // R8 write other
    cyc(s, b + 32'h40, 1'b0, 1'b0);           // R8 readback 00
    cyc(s ^ 4'h1, b + 32'h100, 1'b0, 1'b0);   // R2 foreign id
    idle(2);                                  // R10 standby holds
    cyc(s, b + 32'h100, 1'b0, 1'b1);          // R3 R7 busy read
    cyc(s, b + 32'h100, 1'b1, 1'b1);          // R7 busy write
    cyc(s ^ 4'h8, b + 32'h100, 1'b1, 1'b0);   // R2 foreign write
    for (int k = 0; k < 6; k++) begin         // R4 pins change each cycle
      gpi_pins = 5'(k * 7 + 3);
      cyc(s, b + 32'h100, 1'b0, 1'b0);
    end
    cyc(4'h0, 32'hFFBC_0100, 1'b0, 1'b0);     // boot address with id 0
    idle(1);
  endtask

  initial begin
    gpi_pins = 5'h15;
    idle(3);
    rst = 1'b0;
    idle(1);                                  // R1 state after reset
    strap_phase(4'd0);
    gpi_pins = 5'h0A;
    strap_phase(4'd3);
    strap_phase(4'd15);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule